// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block connects a host bus to three 8-bit parallel ports, A, B and C. The host writes one control register. The top bit of each control write decides what the word means. It either reconfigures the ports, giving each group a mode and a direction, or it sets or clears a single port C line. Group A is port A plus the upper half of port C. Group B is port B plus the lower half of port C.

In the simple mode, written values are held in output latches and inputs are read straight from the pins. In the strobed mode, ports A and B exchange data with a peripheral through handshake lines that borrow port C pins: a strobe, a buffer-full flag, an acknowledge and an interrupt request. The interrupt enable for each handshake is a port C output latch bit, and the host writes it with the single-bit set/clear command.

All host strobes and peripheral handshake pins are sampled by the block clock and are assumed synchronous to it. The data bus appears as separate in and out buses, and every port has explicit output-enable signals in place of pads.

Top module: `pport_ctrl`

## Requirements
- R1: With `cs_n` low, `addr` 0 selects port A, 1 port B, 2 port C and 3 the control register. With `cs_n` high, writes change nothing and `dout` reads 0. A write takes effect at the first clock edge at which `wr_n` is sampled low after being high.
- R2: A control write with bit 7 = 0 is a single-bit command. Bits 3:1 give the port C bit index and bit 0 the new value. It changes only that port C latch bit and leaves the control register unchanged.
- R3: A control write with bit 7 = 1 is stored as the configuration, and reading address 3 returns it. Bits 6:5 = 01 put group A in strobed mode; 00, 10 and 11 give simple mode. Bit 2 = 1 puts group B in strobed mode. Direction bits: bit 4 port A, bit 3 port C 7:4, bit 1 port B, bit 0 port C 3:0, with 1 meaning input.
- R4: After reset the control register reads 0x9B, every output enable is 0, and all latches are 0.
- R5: In simple mode, an output port drives its last written value and reads it back. An input port reads the live pins.
- R6: In strobed input mode, a falling edge of the port's strobe captures the port pins and sets input-buffer-full. The end of a host read of that port clears the flag. The captured value is returned until the next strobe.
- R7: The input-mode interrupt is high only while the strobe is high, the buffer-full flag is set and the enable is set. The enable is PC4 for port A and PC2 for port B.
- R8: In strobed output mode, a host write to the port drives output-buffer-full (active low) to 0. A low acknowledge returns it to 1. It idles at 1.
- R9: The output-mode interrupt is set by a rising acknowledge while the enable is set, and cleared by the next host write to that port. The enable is PC6 for port A and PC2 for port B.
- R10: The handshake pins for port A are interrupt PC3, strobe PC4 / buffer-full PC5 when input, and acknowledge PC6 / buffer-full PC7 when output. For port B they are interrupt PC0, buffer-full PC1 and strobe/acknowledge PC2. Strobe and acknowledge are inputs; the other handshake lines are driven outputs. A port C read returns the live handshake state on those bits. The other port C lines keep simple I/O.
- R11: A configuration write clears the buffer-full flags and interrupts of both handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port / control register select |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, 0 when not reading |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pins in (strobe / acknowledge inputs) |
| pc_out | output | 8 | Port C drive value, latch or handshake |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
Some rules are checked by the assertions on every cycle:
- a deselected bus leaves the port A latch and the configuration untouched;
- a single-bit command flips at most one port C latch bit and never alters the configuration;
- port B buffer-full rises only after a strobe was seen low;
- a port A output-mode write always lowers buffer-full and drops the interrupt on the next cycle;
- the reset state appears when reset releases.

Other behaviour can only be shown by the bench's scenarios:
- the captured strobe data surviving later pin changes;
- buffer-full clearing only after the read has ended;
- interrupt gating by the enable bits set with single-bit commands;
- the exact port C read-back words in each mode.

// File: rtl/pport_pkg.sv
// Package: shared widths, reset value, port C handshake pin positions and
// the host address map for the parallel port controller.
package pport_pkg;
    localparam int PW = 8;                           // port and bus width
    localparam logic [PW-1:0] CTL_RESET = 8'h9B;     // config, all inputs, simple mode

    // Port C handshake pin positions (decoded by the peripheral side)
    localparam int A_INTR = 3;
    localparam int A_STB  = 4;
    localparam int A_IBF  = 5;
    localparam int A_ACK  = 6;
    localparam int A_OBF  = 7;
    localparam int B_INTR = 0;
    localparam int B_BUF  = 1;
    localparam int B_HS   = 2;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;
endpackage

// File: rtl/pport_host_if.sv
// Host strobe front end: turns the level host strobes into one-cycle
// write pulses per target and end-of-read pulses for ports A and B.
// Assumes cs_n, addr, rd_n and wr_n are synchronous to clk.
module pport_host_if
    import pport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    output logic [3:0] wr_sel,
    output logic [1:0] rd_end
);
    logic       wr_n_q;
    logic [1:0] rd_now, rd_q;
    logic       wr_fire;

    // Remember previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_n_q <= 1'b1;
            rd_q   <= '0;
        end else begin
            wr_n_q <= wr_n;
            rd_q   <= rd_now;
        end
    end

    // Decode leading write edge and active reads of ports A/B
    always_comb begin
        wr_fire   = ~cs_n & ~wr_n & wr_n_q;
        wr_sel    = wr_fire ? (4'b0001 << addr) : 4'b0000;
        rd_now[0] = ~cs_n & ~rd_n & (addr == SEL_A);
        rd_now[1] = ~cs_n & ~rd_n & (addr == SEL_B);
        rd_end    = rd_q & ~rd_now;
    end
endmodule

// File: rtl/pport_hs_port.sv
// Handshake engine for one 8-bit port in strobed mode. In input direction
// it captures data on a falling strobe and keeps an input-buffer-full flag.
// In output direction it keeps an active-low output-buffer-full flag and an
// interrupt raised by a rising acknowledge. Idle when hs_en is low.
module pport_hs_port
    import pport_pkg::*;
#(
    parameter int W = PW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hs_en,
    input  logic         is_in,
    input  logic         clr,
    input  logic         host_wr,
    input  logic         rd_end,
    input  logic         hs_pin_n,
    input  logic         inte,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] in_lat,
    output logic         buf_pin,
    output logic         intr
);
    logic pin_q, ibf_q, obf_n_q, ointr_q;
    logic pin_fall, pin_rise, in_act, out_act;

    // Edge and mode qualifiers
    always_comb begin
        pin_fall = pin_q & ~hs_pin_n;
        pin_rise = ~pin_q & hs_pin_n;
        in_act   = hs_en & is_in;
        out_act  = hs_en & ~is_in;
    end

    // Previous level of the strobe / acknowledge pin
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= hs_pin_n;
    end

    // Input side: capture on strobe fall, clear buffer-full after host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf_q  <= 1'b0;
            in_lat <= '0;
        end else if (!in_act || clr) begin
            ibf_q  <= 1'b0;
        end else if (pin_fall) begin
            ibf_q  <= 1'b1;
            in_lat <= port_in;
        end else if (rd_end) begin
            ibf_q  <= 1'b0;
        end
    end

    // Output side: buffer-full and interrupt from host write / acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n || !out_act || clr) begin
            obf_n_q <= 1'b1;
            ointr_q <= 1'b0;
        end else begin
            if (host_wr)        obf_n_q <= 1'b0;
            else if (!hs_pin_n) obf_n_q <= 1'b1;
            if (host_wr)                obf_n_q <= 1'b0;
            if (host_wr)                ointr_q <= 1'b0;
            else if (pin_rise && inte)  ointr_q <= 1'b1;
        end
    end

    // Pin-level results
    always_comb begin
        intr    = in_act ? (hs_pin_n & ibf_q & inte) : ointr_q;
        buf_pin = is_in ? ibf_q : obf_n_q;
    end
endmodule

// File: rtl/pport_ctrl.sv
// Top of the parallel port controller. Holds the configuration register
// and the three output latches. It runs the two handshake engines and builds
// the port C drive, enable and read-back values from the configured modes.
// Assumes all inputs are synchronous to clk; the bus is split into din/dout.
module pport_ctrl
    import pport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic          pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic          pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);
    logic [3:0]    wr_sel;
    logic [1:0]    rd_end;
    logic [PW-1:0] ctl_q, pa_lat, pb_lat, pc_lat, pc_rd, rd_mux;
    logic [PW-1:0] a_inlat, b_inlat;
    logic          ctl_wr, cfg_wr, bsr_wr;
    logic          a_hs, a_in, cu_in, b_hs, b_in, cl_in;
    logic          a_pin, a_inte, a_buf, a_intr, b_buf, b_intr;

    pport_host_if u_host (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .wr_sel (wr_sel),
        .rd_end (rd_end)
    );

    // Split control writes and decode configuration fields
    always_comb begin
        ctl_wr = wr_sel[SEL_CTL];
        cfg_wr = ctl_wr & din[7];
        bsr_wr = ctl_wr & ~din[7];
        a_hs   = (ctl_q[6:5] == 2'b01);
        a_in   = ctl_q[4];
        cu_in  = ctl_q[3];
        b_hs   = ctl_q[2];
        b_in   = ctl_q[1];
        cl_in  = ctl_q[0];
        a_pin  = a_in ? pc_in[A_STB]  : pc_in[A_ACK];
        a_inte = a_in ? pc_lat[A_STB] : pc_lat[A_ACK];
    end

    // Configuration register and output latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RESET;
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
        end else begin
            if (cfg_wr)          ctl_q  <= din;
            if (wr_sel[SEL_A])   pa_lat <= din;
            if (wr_sel[SEL_B])   pb_lat <= din;
            if (wr_sel[SEL_C])   pc_lat <= din;
            else if (bsr_wr)     pc_lat[din[3:1]] <= din[0];
        end
    end

    pport_hs_port #(.W(PW)) u_hs_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (a_hs),
        .is_in    (a_in),
        .clr      (cfg_wr),
        .host_wr  (wr_sel[SEL_A]),
        .rd_end   (rd_end[0]),
        .hs_pin_n (a_pin),
        .inte     (a_inte),
        .port_in  (pa_in),
        .in_lat   (a_inlat),
        .buf_pin  (a_buf),
        .intr     (a_intr)
    );

    pport_hs_port #(.W(PW)) u_hs_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (b_hs),
        .is_in    (b_in),
        .clr      (cfg_wr),
        .host_wr  (wr_sel[SEL_B]),
        .rd_end   (rd_end[1]),
        .hs_pin_n (pc_in[B_HS]),
        .inte     (pc_lat[B_HS]),
        .port_in  (pb_in),
        .in_lat   (b_inlat),
        .buf_pin  (b_buf),
        .intr     (b_intr)
    );

    // Port C: simple I/O per half, then handshake takeover of pins
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            pc_oe[i]  = ~((i >= PW/2) ? cu_in : cl_in);
            pc_out[i] = pc_lat[i];
            pc_rd[i]  = pc_oe[i] ? pc_lat[i] : pc_in[i];
        end
        if (a_hs) begin
            pc_oe[A_INTR] = 1'b1; pc_out[A_INTR] = a_intr; pc_rd[A_INTR] = a_intr;
            if (a_in) begin
                pc_oe[A_STB] = 1'b0; pc_rd[A_STB] = pc_in[A_STB];
                pc_oe[A_IBF] = 1'b1; pc_out[A_IBF] = a_buf; pc_rd[A_IBF] = a_buf;
            end else begin
                pc_oe[A_ACK] = 1'b0; pc_rd[A_ACK] = pc_in[A_ACK];
                pc_oe[A_OBF] = 1'b1; pc_out[A_OBF] = a_buf; pc_rd[A_OBF] = a_buf;
            end
        end
        if (b_hs) begin
            pc_oe[B_INTR] = 1'b1; pc_out[B_INTR] = b_intr; pc_rd[B_INTR] = b_intr;
            pc_oe[B_BUF]  = 1'b1; pc_out[B_BUF]  = b_buf;  pc_rd[B_BUF]  = b_buf;
            pc_oe[B_HS]   = 1'b0; pc_rd[B_HS]    = pc_in[B_HS];
        end
    end

    // Port A/B drive and host read multiplexer
    always_comb begin
        pa_out = pa_lat;
        pa_oe  = ~a_in;
        pb_out = pb_lat;
        pb_oe  = ~b_in;
        case (sel_e'(addr))
            SEL_A:   rd_mux = a_in ? (a_hs ? a_inlat : pa_in) : pa_lat;
            SEL_B:   rd_mux = b_in ? (b_hs ? b_inlat : pb_in) : pb_lat;
            SEL_C:   rd_mux = pc_rd;
            default: rd_mux = ctl_q;
        endcase
        dout = (~cs_n & ~rd_n) ? rd_mux : '0;
    end
endmodule

// File: rtl/pport_ctrl_chk.sv
// Assertion checker for pport_ctrl, attached by bind. Watches the host
// decode, the configuration and latch state, and the port C handshake pins.
module pport_ctrl_chk
    import pport_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          bsr_wr,
    input logic          wr_a,
    input logic          a_hs,
    input logic          a_in,
    input logic          b_hs,
    input logic          b_in,
    input logic [PW-1:0] pc_in,
    input logic [PW-1:0] pc_out,
    input logic [PW-1:0] pc_oe,
    input logic [PW-1:0] pa_out,
    input logic          pa_oe,
    input logic          pb_oe,
    input logic [PW-1:0] ctl_q,
    input logic [PW-1:0] pc_lat
);
    // R1: deselected bus leaves latch and configuration untouched
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(pa_out) && $stable(ctl_q)));

    // R2: single-bit command touches at most one port C bit, not the config
    a_r2_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1 && $stable(ctl_q)));

    // R4: reset state visible as reset releases
    a_r4_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (!pa_oe && !pb_oe && pc_oe == '0 && ctl_q == CTL_RESET));

    // R6: port B buffer-full only rises after the strobe was low
    a_r6_ibf_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (b_hs && b_in && $past(b_hs && b_in) && $rose(pc_out[B_BUF])) |-> !$past(pc_in[B_HS]));

    // R7: input interrupt never without buffer-full
    a_r7_intr_needs_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        (b_hs && b_in && pc_out[B_INTR]) |-> pc_out[B_BUF]);

    // R8: output-mode host write lowers buffer-full
    a_r8_obf_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hs && !a_in && wr_a) |=> !pc_out[A_OBF]);

    // R9: output-mode host write drops the interrupt
    a_r9_intr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hs && !a_in && wr_a) |=> !pc_out[A_INTR]);
endmodule

bind pport_ctrl pport_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .bsr_wr (bsr_wr),
    .wr_a   (wr_sel[0]),
    .a_hs   (a_hs),
    .a_in   (a_in),
    .b_hs   (b_hs),
    .b_in   (b_in),
    .pc_in  (pc_in),
    .pc_out (pc_out),
    .pc_oe  (pc_oe),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pb_oe  (pb_oe),
    .ctl_q  (ctl_q),
    .pc_lat (pc_lat)
);

// File: tb/pport_ctrl_tb.sv
// Bench for pport_ctrl: a table of simple-mode host accesses, then directed
// tests for deselect, reset, strobed input/output and port C takeover.
module pport_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] din = '0, pa_in = '0, pb_in = '0, pc_in = 8'hFF;
    logic [7:0] dout, pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;   // 50 MHz

    pport_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // kind(1=read) | addr | data | pin value | expected read
    localparam int NV = 17;
    localparam logic [26:0] VEC [0:NV-1] = '{
        {1'b0, 2'd3, 8'h80, 8'h00, 8'h00},   // all outputs, simple mode
        {1'b0, 2'd0, 8'h5A, 8'h00, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h00, 8'h5A},   // R5 latched output
        {1'b0, 2'd1, 8'hC3, 8'h00, 8'h00},
        {1'b1, 2'd1, 8'h00, 8'h00, 8'hC3},   // R1 port B select
        {1'b0, 2'd2, 8'h3C, 8'h00, 8'h00},
        {1'b1, 2'd2, 8'h00, 8'h00, 8'h3C},   // R1 port C select
        {1'b0, 2'd3, 8'h91, 8'h77, 8'h00},   // R3 A in, C low in
        {1'b1, 2'd0, 8'h00, 8'h77, 8'h77},   // R5 live input
        {1'b1, 2'd1, 8'h00, 8'h77, 8'hC3},
        {1'b1, 2'd2, 8'h00, 8'h77, 8'h37},   // R3 halves of C
        {1'b1, 2'd0, 8'h00, 8'hE1, 8'hE1},   // R5 unlatched input
        {1'b0, 2'd3, 8'h0F, 8'h00, 8'h00},   // R2 set PC7
        {1'b1, 2'd2, 8'h00, 8'h00, 8'hB0},
        {1'b0, 2'd3, 8'h08, 8'h00, 8'h00},   // R2 clear PC4
        {1'b1, 2'd2, 8'h00, 8'h00, 8'hA0},
        {1'b1, 2'd3, 8'h00, 8'h00, 8'h91}    // R2 R3 config unchanged
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
        #1 d = dout;
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4 reset state
        chk("R4 pa_oe", {7'd0, pa_oe}, 8'h00);
        chk("R4 pc_oe", pc_oe, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 pb_oe", {7'd0, pb_oe}, 8'h00);
        chk("R4 pa_out", pa_out, 8'h00);
        rd(2'd3, rv); chk("R4 ctl", rv, 8'h9B);

        // Simple-mode table
        for (int i = 0; i < NV; i++) begin
            pa_in = VEC[i][15:8]; pb_in = VEC[i][15:8]; pc_in = VEC[i][15:8];
            if (VEC[i][26]) begin
                rd(VEC[i][25:24], rv);
                chk($sformatf("R5/R3/R2 table row %0d", i), rv, VEC[i][7:0]);
            end else begin
                wr(VEC[i][25:24], VEC[i][23:16]);
            end
        end
        pc_in = 8'hFF;

        // R1 deselected access
        wr(2'd3, 8'h80);
        wr(2'd0, 8'h11);
        chk("R1 write A", pa_out, 8'h11);
        @(negedge clk); cs_n = 1'b1; addr = 2'd0; din = 8'h22; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        chk("R1 ignored write", pa_out, 8'h11);
        @(negedge clk); rd_n = 1'b0; #1 chk("R1 deselected read", dout, 8'h00);
        @(negedge clk); rd_n = 1'b1;

        // R6 R7 strobed input on port B
        wr(2'd3, 8'h86);
        wr(2'd3, 8'h05);                      // PC2 enable on
        chk("R10 port B pin dirs", {5'd0, pc_oe[2:0]}, 8'h03);
        chk("R6 ibf idle", {7'd0, pc_out[1]}, 8'h00);
        @(negedge clk); pb_in = 8'h6D; pc_in[2] = 1'b0;
        @(negedge clk);
        chk("R6 ibf set", {7'd0, pc_out[1]}, 8'h01);
        chk("R7 no intr while strobe low", {7'd0, pc_out[0]}, 8'h00);
        pc_in[2] = 1'b1; pb_in = 8'h00;
        @(negedge clk);
        chk("R7 intr", {7'd0, pc_out[0]}, 8'h01);
        rd(2'd2, rv); chk("R10 port C readback B", rv, 8'hAF);
        rd(2'd1, rv); chk("R6 captured data", rv, 8'h6D);
        @(negedge clk);
        chk("R6 ibf cleared", {7'd0, pc_out[1]}, 8'h00);
        chk("R7 intr cleared", {7'd0, pc_out[0]}, 8'h00);
        wr(2'd3, 8'h04);                      // PC2 enable off
        @(negedge clk); pc_in[2] = 1'b0;
        @(negedge clk); pc_in[2] = 1'b1;
        @(negedge clk);
        chk("R6 ibf second", {7'd0, pc_out[1]}, 8'h01);
        chk("R7 intr gated off", {7'd0, pc_out[0]}, 8'h00);
        wr(2'd3, 8'h86);
        chk("R11 config clears ibf", {7'd0, pc_out[1]}, 8'h00);

        // R8 R9 strobed output on port A
        wr(2'd3, 8'hA0);
        wr(2'd3, 8'h0D);                      // PC6 enable on
        chk("R8 obf idle", {7'd0, pc_out[7]}, 8'h01);
        chk("R10 ack pin input", {7'd0, pc_oe[6]}, 8'h00);
        wr(2'd0, 8'h99);
        chk("R8 obf low", {7'd0, pc_out[7]}, 8'h00);
        chk("R8 data", pa_out, 8'h99);
        @(negedge clk); pc_in[6] = 1'b0;
        @(negedge clk);
        chk("R8 obf released", {7'd0, pc_out[7]}, 8'h01);
        chk("R9 no intr before rise", {7'd0, pc_out[3]}, 8'h00);
        pc_in[6] = 1'b1;
        @(negedge clk);
        chk("R9 intr on rise", {7'd0, pc_out[3]}, 8'h01);
        wr(2'd0, 8'h42);
        chk("R9 intr cleared by write", {7'd0, pc_out[3]}, 8'h00);
        rd(2'd2, rv); chk("R10 port C readback A", rv, 8'h60);

        // R3 unsupported group A encoding acts as simple mode
        wr(2'd3, 8'hC0);
        wr(2'd2, 8'h5A);
        chk("R3 mode 1x pc_out", pc_out, 8'h5A);
        chk("R3 mode 1x pc_oe", pc_oe, 8'hFF);

        // R10 port A input takeover, spare upper lines stay simple
        wr(2'd3, 8'hB0);
        chk("R10 pin dirs A input", pc_oe, 8'hEF);
        chk("R10 spare lines", {6'd0, pc_out[7:6]}, 8'h01);

        finish_run();
    end
endmodule